// File: doc/BRIEF.md
# Register-Write Command Packer

This block turns a stream of register-write requests into a packed list of 64-bit instructions held in a dword-addressed command RAM. Each request carries a register offset, a 32-bit value and a 32-bit mask. A request may be a plain write, a masked write, a no-op or a finish. The packer tracks two pointers. The free pointer marks the next unused dword. The start pointer marks the first dword of the most recent instruction.

When a plain write targets the same register as the instruction just emitted, the packer does not emit a new instruction. If that previous instruction was a single full-byte-enable write, it is rewritten in place into an indexed burst. If it was already an indexed burst, the new value is appended to it. The count word and the zero padding are updated to match.

A finish request zero-fills the RAM up to the next 64-byte line and reports the tail in bytes. A downstream engine can then fetch the stream. The contents of the RAM can be read back through a combinational read port.

Top module: `regwr_packer`

## Requirements
- R1: After reset or a `clear` strobe, the free pointer and the start pointer are zero, `overflow` is low and `req_ready` is high. The first write after that is never merged and lands at dword 0.
- R2: Each new instruction starts at an even dword: the free pointer is rounded up to even first. A plain write (kind 0) stores the value at dword s and the control word {8'h01, 4'hF, offset[19:0]} at dword s+1.
- R3: A write, masked write or no-op that arrives while the free pointer exceeds DEPTH-2 writes nothing. It sets `overflow`, which stays high until `clear` or reset.
- R4: A plain write to the same offset as a previous full-byte-enable write rewrites that instruction. Dword s becomes the count, dword s+1 becomes {8'h09, 4'h0, offset}, dword s+2 holds the earlier value and dword s+3 the new one. The count reads 2 after the merge.
- R5: A plain write to the offset of a current indexed burst appends its value at the free pointer and increments the count at dword s. If the free pointer is then odd, the dword at the free pointer is written to zero.
- R6: A masked write (kind 1) sets byte-enable bit i when any bit of mask byte i is set. It stores the value at s and {8'h01, byte_enables, offset} at s+1.
- R7: A masked write never merges into the previous instruction. A plain write may merge into an earlier masked write only when that masked write had all four byte enables set.
- R8: A plain write to a different offset than the previous instruction starts a new instruction.
- R9: A no-op (kind 2) stores two zero dwords. A following write is never merged across it.
- R10: A finish (kind 3) zero-fills from the free pointer up to the next multiple of 16 dwords. It then pulses `tail_valid` for one cycle with `tail_bytes` equal to that aligned pointer times 4. No fill happens when the pointer is already aligned. The next write starts a new instruction.
- R11: `req_ready` is high only when the packer is idle. An accepted, non-dropped request holds it low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous restart of both pointers and of the overflow flag |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Packer idle; a valid request is taken on this edge |
| req_kind | input | 2 | 0 plain write, 1 masked write, 2 no-op, 3 finish |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Register value |
| req_mask | input | 32 | Bit mask; used only by masked writes |
| overflow | output | 1 | Sticky: a request was dropped for lack of room |
| tail_valid | output | 1 | One-cycle pulse when a finish completes |
| tail_bytes | output | AW+3 | Aligned stream length in bytes |
| rd_addr | input | AW | Read-port dword address |
| rd_data | output | 32 | Read-port dword contents |

## Verification
The properties assume that `req_kind` and the other request fields stay stable while `req_valid` is high and `req_ready` is low. They also assume that `clear` arrives only between requests, and that DEPTH is a multiple of the 16-dword line. The stimulus drives requests only on falling edges and holds every field until the request is accepted. It raises `clear` only after the packer is idle again. The random rounds pick offsets from a set of three registers, so merging, masked-write breaks, no-op breaks and overflow all occur often. Each round is checked dword by dword against a model built from the requirements.

// File: rtl/rwp_pkg.sv
// Shared definitions for the register-write packer: request kinds,
// last-instruction classes and instruction field values.
package rwp_pkg;
    localparam int OFF_W = 20;
    localparam int OPC_W = 8;
    localparam int BE_W  = 4;

    typedef enum logic [1:0] {
        K_WRITE  = 2'd0,
        K_MASKED = 2'd1,
        K_NOOP   = 2'd2,
        K_FINISH = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        L_NONE  = 2'd0,
        L_FULL  = 2'd1,
        L_IDX   = 2'd2,
        L_OTHER = 2'd3
    } last_e;

    localparam logic [OPC_W-1:0] OPC_WR  = 8'h01;
    localparam logic [OPC_W-1:0] OPC_IDX = 8'h09;
endpackage

// File: rtl/rwp_byte_en.sv
// Reduces a bit mask to one enable per byte lane.
// Assumes DW is a multiple of 8.
module rwp_byte_en #(
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic [DW-1:0] mask,
    output logic [NB-1:0] be
);
    // One OR-reduction per lane.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign be[i] = |mask[i*8 +: 8];
    end
endmodule

// File: rtl/rwp_ram.sv
// Dword command store: one synchronous write port, one combinational
// read port. Contents are not reset.
module rwp_ram #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    // Store one dword per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rwp_seq.sv
// Packing sequencer: accepts one request while idle and walks through one
// RAM write per cycle. Keeps a shadow of the last instruction (class,
// offset, first value, count), so merging needs no RAM read.
// Assumes DEPTH is a multiple of LINE_DW and request fields are stable
// while req_valid is high.
module rwp_seq
    import rwp_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LINE_DW = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int LW = $clog2(LINE_DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [31:0]      req_value,
    input  logic [BE_W-1:0]  req_be,
    output logic             overflow,
    output logic             tail_valid,
    output logic [PW+1:0]    tail_bytes,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [31:0]      wdata,
    output logic [PW-1:0]    free_ptr,
    output logic [PW-1:0]    start_ptr
);
    typedef enum logic [3:0] {
        S_IDLE, S_EMIT_LO, S_EMIT_HI, S_CNV_CNT, S_CNV_CTRL,
        S_CNV_PREV, S_APP_VAL, S_APP_CNT, S_APP_PAD, S_FILL
    } state_e;

    localparam logic [PW-1:0] LIMIT = PW'(DEPTH - 2);

    state_e           st;
    logic [PW-1:0]    free_q, start_q, cnt_q;
    last_e            last_q;
    logic [OFF_W-1:0] last_off_q, off_q;
    logic [31:0]      last_val_q, val_q;
    logic [BE_W-1:0]  be_q;
    kind_e            kind_q, kind_in;
    logic             ovf_q, tail_v_q;
    logic [PW+1:0]    tail_q;
    logic [PW-1:0]    free_p1, even_free, start_p1, start_p2;
    logic             merge;

    assign kind_in   = kind_e'(req_kind);
    assign free_p1   = free_q + PW'(1);
    assign even_free = {free_p1[PW-1:1], 1'b0};
    assign start_p1  = start_q + PW'(1);
    assign start_p2  = start_q + PW'(2);
    assign merge     = (kind_in == K_WRITE) && (req_offset == last_off_q) &&
                       ((last_q == L_FULL) || (last_q == L_IDX));

    assign req_ready  = (st == S_IDLE);
    assign overflow   = ovf_q;
    assign tail_valid = tail_v_q;
    assign tail_bytes = tail_q;
    assign free_ptr   = free_q;
    assign start_ptr  = start_q;

    // Sequencer state, pointers and last-instruction shadow.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st         <= S_IDLE;
            free_q     <= '0;
            start_q    <= '0;
            cnt_q      <= '0;
            last_q     <= L_NONE;
            last_off_q <= '0;
            last_val_q <= '0;
            off_q      <= '0;
            val_q      <= '0;
            be_q       <= '0;
            kind_q     <= K_NOOP;
            ovf_q      <= 1'b0;
            tail_v_q   <= 1'b0;
            tail_q     <= '0;
        end else begin
            tail_v_q <= 1'b0;
            case (st)
                S_IDLE: if (req_valid) begin
                    kind_q <= kind_in;
                    off_q  <= req_offset;
                    val_q  <= req_value;
                    be_q   <= req_be;
                    if (kind_in == K_FINISH) begin
                        st <= S_FILL;
                    end else if (free_q > LIMIT) begin
                        ovf_q <= 1'b1;
                    end else if (merge) begin
                        st <= (last_q == L_FULL) ? S_CNV_CNT : S_APP_VAL;
                    end else begin
                        free_q  <= even_free;
                        start_q <= even_free;
                        st      <= S_EMIT_LO;
                    end
                end
                S_EMIT_LO: begin
                    free_q <= free_p1;
                    st     <= S_EMIT_HI;
                end
                S_EMIT_HI: begin
                    free_q     <= free_p1;
                    last_q     <= (kind_q == K_NOOP) ? L_OTHER :
                                  ((be_q == 4'hF) ? L_FULL : L_OTHER);
                    last_off_q <= off_q;
                    last_val_q <= val_q;
                    st         <= S_IDLE;
                end
                S_CNV_CNT:  st <= S_CNV_CTRL;
                S_CNV_CTRL: st <= S_CNV_PREV;
                S_CNV_PREV: begin
                    free_q <= start_q + PW'(3);
                    cnt_q  <= PW'(1);
                    last_q <= L_IDX;
                    st     <= S_APP_VAL;
                end
                S_APP_VAL: begin
                    free_q <= free_p1;
                    cnt_q  <= cnt_q + PW'(1);
                    st     <= S_APP_CNT;
                end
                S_APP_CNT: st <= free_q[0] ? S_APP_PAD : S_IDLE;
                S_APP_PAD: st <= S_IDLE;
                S_FILL: begin
                    if (free_q[LW-1:0] != '0) begin
                        free_q <= free_p1;
                    end else begin
                        tail_v_q <= 1'b1;
                        tail_q   <= {free_q, 2'b00};
                        last_q   <= L_NONE;
                        st       <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // RAM write port: at most one dword per cycle, chosen by state.
    always_comb begin
        we    = 1'b0;
        waddr = free_q[AW-1:0];
        wdata = '0;
        case (st)
            S_EMIT_LO: begin
                we    = 1'b1;
                wdata = (kind_q == K_NOOP) ? '0 : val_q;
            end
            S_EMIT_HI: begin
                we    = 1'b1;
                wdata = (kind_q == K_NOOP) ? '0 : {OPC_WR, be_q, off_q};
            end
            S_CNV_CNT: begin
                we    = 1'b1;
                waddr = start_q[AW-1:0];
                wdata = 32'd1;
            end
            S_CNV_CTRL: begin
                we    = 1'b1;
                waddr = start_p1[AW-1:0];
                wdata = {OPC_IDX, 4'h0, last_off_q};
            end
            S_CNV_PREV: begin
                we    = 1'b1;
                waddr = start_p2[AW-1:0];
                wdata = last_val_q;
            end
            S_APP_VAL: begin
                we    = 1'b1;
                wdata = val_q;
            end
            S_APP_CNT: begin
                we    = 1'b1;
                waddr = start_q[AW-1:0];
                wdata = 32'(cnt_q);
            end
            S_APP_PAD: we = 1'b1;
            S_FILL:    we = (free_q[LW-1:0] != '0);
            default:   we = 1'b0;
        endcase
    end
endmodule

// File: rtl/regwr_packer.sv
// Top of the register-write packer. Derives the byte enables, runs the
// sequencer and holds the command RAM. Plain writes always use all four
// byte enables.
module regwr_packer
    import rwp_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LINE_DW = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [31:0]      req_value,
    input  logic [31:0]      req_mask,
    output logic             overflow,
    output logic             tail_valid,
    output logic [AW+2:0]    tail_bytes,
    input  logic [AW-1:0]    rd_addr,
    output logic [31:0]      rd_data
);
    logic [BE_W-1:0] mask_be, req_be;
    logic            we;
    logic [AW-1:0]   waddr;
    logic [31:0]     wdata;
    logic [PW-1:0]   free_ptr, start_ptr;

    rwp_byte_en #(.DW(32)) u_be (.mask(req_mask), .be(mask_be));

    assign req_be = (req_kind == K_MASKED) ? mask_be : 4'hF;

    rwp_seq #(.DEPTH(DEPTH), .LINE_DW(LINE_DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_offset(req_offset), .req_value(req_value), .req_be(req_be),
        .overflow(overflow), .tail_valid(tail_valid), .tail_bytes(tail_bytes),
        .we(we), .waddr(waddr), .wdata(wdata),
        .free_ptr(free_ptr), .start_ptr(start_ptr)
    );

    rwp_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/rwp_chk.sv
// Property checker for regwr_packer, attached by bind. Assumes request
// fields are stable while a request waits and clear comes only when idle.
module rwp_chk #(
    parameter int DEPTH   = 64,
    parameter int LINE_DW = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int LB = $clog2(LINE_DW * 4)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_kind,
    input logic          overflow,
    input logic          tail_valid,
    input logic [AW+2:0] tail_bytes,
    input logic [PW-1:0] free_ptr,
    input logic [PW-1:0] start_ptr
);
    // R1: clear returns both pointers and the flag to zero
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (free_ptr == '0 && start_ptr == '0 && !overflow));

    // R2: instructions always begin on an even dword
    assert_start_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ptr[0] == 1'b0);

    // R3: overflow is sticky until clear
    assert_no_overflow_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);

    // R3: free pointer never passes the RAM end
    assert_free_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        free_ptr <= PW'(DEPTH));

    // R10: reported tail is a whole number of lines
    assert_tail_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |-> (tail_bytes[LB-1:0] == '0));

    // R10: tail report is a single-cycle pulse
    assert_tail_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |=> !tail_valid);

    // R11: an accepted request that has room makes the packer busy
    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !clear && req_kind != 2'd3 &&
         free_ptr <= PW'(DEPTH - 2)) |=> !req_ready);
endmodule

bind regwr_packer rwp_chk #(.DEPTH(DEPTH), .LINE_DW(LINE_DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .overflow(overflow), .tail_valid(tail_valid), .tail_bytes(tail_bytes),
    .free_ptr(free_ptr), .start_ptr(start_ptr)
);

// File: tb/sim_regwr_packer.sv
// Bench for regwr_packer: directed corners, then seeded random rounds,
// all compared with a model built from the requirements.
module sim_regwr_packer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic        clk = 1'b0, rst_n = 1'b0, clear = 1'b0, req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [19:0] req_offset = '0;
    logic [31:0] req_value = '0, req_mask = '0;
    logic [AW-1:0] rd_addr = '0;
    logic        req_ready, overflow, tail_valid;
    logic [AW+2:0] tail_bytes;
    logic [31:0] rd_data;

    int checks = 0, errors = 0;

    // model state
    logic [31:0] m_mem [DEPTH];
    int          m_free = 0, m_start = 0, m_cnt = 0, m_last = 0, m_tail = 0;
    logic [19:0] m_off = '0;
    logic [31:0] m_val = '0;
    bit          m_ovf = 0;

    regwr_packer u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_offset(req_offset), .req_value(req_value), .req_mask(req_mask),
        .overflow(overflow), .tail_valid(tail_valid), .tail_bytes(tail_bytes),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] be_of(input logic [31:0] m);
        for (int i = 0; i < 4; i++) be_of[i] = |m[i*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model kinds: last 0 none, 1 full write, 2 indexed, 3 other.
    task automatic model_req(input int kind, input logic [19:0] off,
                             input logic [31:0] val, input logic [31:0] mask);
        logic [3:0] be;
        if (kind == 3) begin
            while (m_free % 16 != 0) begin m_mem[m_free] = 0; m_free++; end
            m_tail = m_free * 4;
            m_last = 0;
            return;
        end
        if (m_free > DEPTH - 2) begin m_ovf = 1; return; end
        if (kind == 0 && (m_last == 1 || m_last == 2) && m_off == off) begin
            if (m_last == 1) begin
                m_mem[m_start]     = 1;
                m_mem[m_start + 1] = {8'h09, 4'h0, off};
                m_mem[m_start + 2] = m_val;
                m_free = m_start + 3;
                m_cnt  = 1;
                m_last = 2;
            end
            m_mem[m_free] = val;
            m_free++;
            m_cnt++;
            m_mem[m_start] = m_cnt;
            if (m_free % 2 == 1) m_mem[m_free] = 0;
        end else begin
            m_free  = (m_free + 1) & ~1;
            m_start = m_free;
            if (kind == 2) begin
                m_mem[m_free] = 0; m_mem[m_free + 1] = 0; m_last = 3;
            end else begin
                be = (kind == 1) ? be_of(mask) : 4'hF;
                m_mem[m_free]     = val;
                m_mem[m_free + 1] = {8'h01, be, off};
                m_last = (be == 4'hF) ? 1 : 3;
                m_off  = off;
                m_val  = val;
            end
            m_free += 2;
        end
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic send(input int kind, input logic [19:0] off,
                        input logic [31:0] val, input logic [31:0] mask);
        bit seen = 0;
        model_req(kind, off, val, mask);
        @(negedge clk);
        req_kind = kind[1:0]; req_offset = off; req_value = val; req_mask = mask;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == 3) begin
            for (int i = 0; i < 40 && !seen; i++) begin
                if (tail_valid) seen = 1; else @(negedge clk);
            end
            chk("R10 tail pulse seen", 32'(seen), 32'd1);
            chk("R10 tail bytes", 32'(tail_bytes), 32'(m_tail));
        end
    endtask

    task automatic check_mem(input string tag);
        wait_idle();
        for (int i = 0; i < m_free; i++) begin
            rd_addr = AW'(i);
            #1;
            chk(tag, rd_data, m_mem[i]);
        end
        chk({tag, " overflow"}, 32'(overflow), 32'(m_ovf));
    endtask

    task automatic peek(input string tag, input int a, input logic [31:0] exp);
        wait_idle();
        rd_addr = AW'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic do_clear();
        wait_idle();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        m_free = 0; m_start = 0; m_cnt = 0; m_last = 0; m_ovf = 0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        int r, k;
        logic [19:0] off;
        logic [31:0] msk;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 overflow after reset", 32'(overflow), 32'd0);

        send(0, 20'h00ABC, 32'hAAAA0001, 32'h0);
        check_mem("R2 plain write");
        peek("R2 control word", 1, {8'h01, 4'hF, 20'h00ABC});
        send(0, 20'h00ABC, 32'hBBBB0002, 32'h0);
        check_mem("R4 merge");
        peek("R4 count", 0, 32'd2);
        peek("R4 indexed ctrl", 1, {8'h09, 4'h0, 20'h00ABC});
        send(0, 20'h00ABC, 32'hCCCC0003, 32'h0);
        check_mem("R5 append");
        peek("R5 count", 0, 32'd3);
        peek("R5 odd pad", 5, 32'd0);
        send(0, 20'h00123, 32'h11112222, 32'h0);
        check_mem("R8 other reg");
        send(1, 20'h00010, 32'h5555AAAA, 32'h00FF0001);
        check_mem("R6 masked");
        peek("R6 byte enables", 9, {8'h01, 4'b0101, 20'h00010});
        send(1, 20'h00010, 32'h12345678, 32'hFFFFFFFF);
        send(1, 20'h00010, 32'h9ABCDEF0, 32'hFFFFFFFF);
        check_mem("R7 masked no merge");
        send(0, 20'h00010, 32'h0F0F0F0F, 32'h0);
        check_mem("R7 plain onto full masked");
        send(0, 20'h00777, 32'h1, 32'h0);
        send(2, 20'h0, 32'h0, 32'h0);
        send(0, 20'h00777, 32'h2, 32'h0);
        check_mem("R9 noop break");
        send(3, 20'h0, 32'h0, 32'h0);
        check_mem("R10 fill");
        send(0, 20'h00777, 32'h3, 32'h0);
        check_mem("R10 no merge after finish");

        do_clear();
        chk("R1 overflow after clear", 32'(overflow), 32'd0);
        send(3, 20'h0, 32'h0, 32'h0);
        send(0, 20'h00777, 32'h4, 32'h0);
        check_mem("R1 first write at zero");
        do_clear();
        for (int i = 0; i < DEPTH / 2; i++) send(0, 20'(i * 4), 32'(i), 32'h0);
        send(0, 20'h00FFF, 32'hDEAD, 32'h0);
        check_mem("R3 overflow");
        chk("R3 overflow flag", 32'(overflow), 32'd1);

        for (int round = 0; round < 8; round++) begin
            do_clear();
            for (int n = 0; n < 45; n++) begin
                r   = $urandom % 20;
                k   = (r < 12) ? 0 : (r < 16) ? 1 : (r < 18) ? 2 : 3;
                off = 20'h40 + 20'(($urandom % 3) * 4);
                msk = ($urandom % 3 == 0) ? 32'hFFFFFFFF : $urandom;
                send(k, off, $urandom, msk);
            end
            send(3, 20'h0, 32'h0, 32'h0);
            check_mem("R5 random round");
        end
        summary();
    end
endmodule